// File: doc/BRIEF.md
# Discard Time-Out Event Log

This block sits beside one port of a packet switch and keeps a record of packets that the switch threw away because they waited too long. Three single-cycle event inputs report such drops, one for each traffic class: posted, non-posted and completion. For each class the block holds a sticky flag and an 8-bit saturating drop counter. When a flag goes from clear to set, the block emits a one-cycle report pulse. The pulse goes out on one of three severity outputs (correctable, non-fatal or fatal), or on none of them, as a 2-bit setting for that class selects.

Software reaches the flags, counters and severity settings through a small register port. Writes take effect on the clock edge and reads are combinational. The flags clear when software writes a one to them, and the counters clear when software writes zero to them. A cold reset returns everything to zero. A hot reset leaves the logged state untouched and only silences the report outputs.

Top module: `discard_timeout_log`

## Requirements
- R1: A drop event on class input bit k sets flag k. The flag register sits at address 0, with bit 0 for posted, bit 1 for non-posted and bit 2 for completion, and the set is visible after the next clock edge.
- R2: Each drop event adds one to that class's counter at address 1. The posted count is in bits [7:0], non-posted in [15:8] and completion in [23:16].
- R3: A counter that holds 255 stays at 255 on further drops and never wraps to 0.
- R4: A report pulse is high for exactly the one cycle after the clock edge on which a flag went from 0 to 1. A drop whose flag is already set produces no pulse.
- R5: Writing 0 to a flag bit leaves it unchanged, and writing 1 clears it. A drop in the same cycle as the clearing write keeps the flag set and raises no pulse, because the flag was already set.
- R6: The severity register at address 2 holds 2 bits per class: [1:0] posted, [3:2] non-posted, [5:4] completion. Code 00 sends no report, 01 pulses rpt_corr, 10 pulses rpt_nonfatal and 11 pulses rpt_fatal. When several classes rise in the same cycle, their outputs are ORed together.
- R7: A write to address 1 clears each counter whose byte in the write data is zero and leaves alone each counter whose byte is non-zero. A drop in the same cycle wins, and that counter increments instead.
- R8: A cold reset (rst_n low) clears flags, counters, severity settings and reports. hot_rst leaves flags, counters and settings unchanged and forces all report outputs low in the following cycle.
- R9: Reads at address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low |
| hot_rst | input | 1 | Hot reset; silences reports only |
| drop_evt | input | 3 | Drop pulses: bit 0 posted, bit 1 non-posted, bit 2 completion |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for reg_addr |
| rpt_corr | output | 1 | Correctable report pulse |
| rpt_nonfatal | output | 1 | Non-fatal report pulse |
| rpt_fatal | output | 1 | Fatal report pulse |

## Verification
The bench repeats drops while a flag is already set. A design that reports on every drop, rather than on the rising edge of the flag, would pulse again there. It drives more than 255 drops into one class, so a counter that wraps would show a small value. Clearing writes are issued in the same cycle as a drop, both for flags and for counters; a design that let the clear win would show a cleared flag or a zero count. It also writes zero to flags, writes per-byte counter masks, asserts hot reset during a drop, and uses mixed severity codes across classes. These catch a clear on any write, one byte clearing all counters, state lost on hot reset and misrouted severities.

// File: rtl/discard_timeout_log.sv
module discard_timeout_log #(
  parameter int CNT_W  = 8,
  parameter int N_TYPE = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hot_rst,
  input  logic [N_TYPE-1:0]         drop_evt,
  input  logic                      reg_wr,
  input  logic [1:0]                reg_addr,
  input  logic [N_TYPE*CNT_W-1:0]   reg_wdata,
  output logic [N_TYPE*CNT_W-1:0]   reg_rdata,
  output logic                      rpt_corr,
  output logic                      rpt_nonfatal,
  output logic                      rpt_fatal
);
  localparam int RW = N_TYPE*CNT_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [N_TYPE-1:0]   sts_q;
  logic [CNT_W-1:0]    cnt_q [N_TYPE];
  logic [2*N_TYPE-1:0] ctl_q;
  logic [2:0]          rpt_q;
  logic [2:0]          sev;

  wire wr_sts = reg_wr && (reg_addr == 2'd0);
  wire wr_cnt = reg_wr && (reg_addr == 2'd1);
  wire wr_ctl = reg_wr && (reg_addr == 2'd2);
  wire [N_TYPE-1:0] rise = drop_evt & ~sts_q;
  wire [N_TYPE-1:0] clr  = wr_sts ? reg_wdata[N_TYPE-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr) | drop_evt;

  for (genvar g = 0; g < N_TYPE; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        cnt_q[g] <= '0;
      else if (drop_evt[g]) begin
        if (cnt_q[g] != CMAX) cnt_q[g] <= cnt_q[g] + 1'b1;
      end else if (wr_cnt && reg_wdata[g*CNT_W +: CNT_W] == '0)
        cnt_q[g] <= '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= reg_wdata[2*N_TYPE-1:0];

  always_comb begin
    sev = '0;
    for (int i = 0; i < N_TYPE; i++)
      if (rise[i] && ctl_q[2*i +: 2] != 2'b00)
        sev[ctl_q[2*i +: 2] - 2'd1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rpt_q <= '0;
    else        rpt_q <= hot_rst ? 3'b000 : sev;

  assign rpt_corr     = rpt_q[0];
  assign rpt_nonfatal = rpt_q[1];
  assign rpt_fatal    = rpt_q[2];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[N_TYPE-1:0] = sts_q;
      2'd1: for (int i = 0; i < N_TYPE; i++) reg_rdata[i*CNT_W +: CNT_W] = cnt_q[i];
      2'd2: reg_rdata[2*N_TYPE-1:0] = ctl_q;
      default: reg_rdata = {RW{1'b0}};
    endcase
  end
endmodule

module discard_timeout_log_chk #(
  parameter int CNT_W  = 8,
  parameter int N_TYPE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hot_rst,
  input logic [N_TYPE-1:0] drop_evt,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [N_TYPE-1:0] w1c,
  input logic [N_TYPE-1:0] sts,
  input logic [CNT_W-1:0]  cnt [N_TYPE],
  input logic [2:0]        rpt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  for (genvar g = 0; g < N_TYPE; g++) begin : g_prop
    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      drop_evt[g] |=> sts[g]);
    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      drop_evt[g] && cnt[g] != CMAX |=> cnt[g] == CNT_W'($past(cnt[g]) + 1'b1));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      drop_evt[g] && cnt[g] == CMAX |=> cnt[g] == CMAX);
    p_w1c_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[g]) |-> $past(reg_wr && reg_addr == 2'd0 && w1c[g]));
  end

  p_rpt_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rpt != 3'b000 |-> (sts & ~$past(sts)) != '0);
  p_hot_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hot_rst |=> rpt == 3'b000);
endmodule

bind discard_timeout_log discard_timeout_log_chk #(.CNT_W(CNT_W), .N_TYPE(N_TYPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .hot_rst(hot_rst), .drop_evt(drop_evt),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .w1c(reg_wdata[N_TYPE-1:0]),
  .sts(sts_q), .cnt(cnt_q), .rpt({rpt_fatal, rpt_nonfatal, rpt_corr})
);

// File: tb/discard_timeout_log_tb_top.sv
module discard_timeout_log_tb_top;
  logic clk = 0, rst_n = 0, hot_rst = 0, reg_wr = 0;
  logic [2:0]  drop_evt = 0;
  logic [1:0]  reg_addr = 0;
  logic [23:0] reg_wdata = 0;
  logic [23:0] reg_rdata;
  logic rpt_corr, rpt_nonfatal, rpt_fatal;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [2:0] m_sts;
  logic [7:0] m_cnt [3];
  logic [1:0] m_ctl [3];

  always #2 clk = ~clk;

  discard_timeout_log dut_i (
    .clk(clk), .rst_n(rst_n), .hot_rst(hot_rst), .drop_evt(drop_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rpt_corr(rpt_corr), .rpt_nonfatal(rpt_nonfatal),
    .rpt_fatal(rpt_fatal)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_sts = 0;
    for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_ctl[i] = 0; end
  endtask

  task automatic cyc(input string tag, input logic [2:0] d, input logic w,
                     input logic [1:0] a, input logic [23:0] wd, input logic h);
    logic [2:0] exp_rpt;
    @(negedge clk);
    drop_evt = d; reg_wr = w; reg_addr = a; reg_wdata = wd; hot_rst = h;
    exp_rpt = 0;
    for (int i = 0; i < 3; i++)
      if (!h && d[i] && !m_sts[i] && m_ctl[i] != 0) exp_rpt[m_ctl[i] - 2'd1] = 1'b1;
    if (w && a == 0) m_sts = m_sts & ~wd[2:0];
    m_sts = m_sts | d;
    for (int i = 0; i < 3; i++) begin
      if (d[i]) begin
        if (m_cnt[i] != 8'hFF) m_cnt[i] = m_cnt[i] + 1;
      end else if (w && a == 1 && wd[i*8 +: 8] == 0) m_cnt[i] = 0;
      if (w && a == 2) m_ctl[i] = wd[2*i +: 2];
    end
    @(posedge clk);
    #1;
    chk({tag, " report"}, {21'd0, rpt_fatal, rpt_nonfatal, rpt_corr}, {21'd0, exp_rpt});
    drop_evt = 0; reg_wr = 0; hot_rst = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic chk_regs(input string tag);
    logic [23:0] v;
    rd(2'd0, v); chk({tag, " flags"}, v, {21'd0, m_sts});
    rd(2'd1, v); chk({tag, " counts"}, v, {m_cnt[2], m_cnt[1], m_cnt[0]});
    rd(2'd2, v); chk({tag, " severity"}, v, {18'd0, m_ctl[2], m_ctl[1], m_ctl[0]});
  endtask

  task automatic t_reset();
    logic [23:0] v;
    model_clear();
    chk_regs("R8 cold reset");
    rd(2'd3, v); chk("R9 addr3", v, 24'd0);
    chk("R8 reports idle", {21'd0, rpt_fatal, rpt_nonfatal, rpt_corr}, 24'd0);
  endtask

  task automatic t_severity_setup();
    cyc("R6 write severity", 3'b000, 1, 2'd2, 24'b11_10_01, 0);
    chk_regs("R6 severity readback");
  endtask

  task automatic t_first_drops();
    cyc("R1 R4 R6 posted corr", 3'b001, 0, 0, 0, 0);
    chk_regs("R1 R2 posted");
    cyc("R4 repeat posted silent", 3'b001, 0, 0, 0, 0);
    cyc("R6 nonposted nonfatal", 3'b010, 0, 0, 0, 0);
    cyc("R6 completion fatal", 3'b100, 0, 0, 0, 0);
    chk_regs("R2 after mixed drops");
  endtask

  task automatic t_w1c();
    cyc("R5 write zero to flags", 3'b000, 1, 2'd0, 24'd0, 0);
    chk_regs("R5 zero write no effect");
    cyc("R5 clear posted flag", 3'b000, 1, 2'd0, 24'd1, 0);
    chk_regs("R5 posted cleared");
    cyc("R5 R4 posted re-report", 3'b001, 0, 0, 0, 0);
    cyc("R5 clear with same-cycle drop", 3'b010, 1, 2'd0, 24'd2, 0);
    chk_regs("R5 drop beats clear");
  endtask

  task automatic t_counter();
    cyc("R7 clear posted byte only", 3'b000, 1, 2'd1, 24'hFFFF00, 0);
    chk_regs("R7 per-byte clear");
    for (int k = 0; k < 260; k++) cyc("R3 posted flood", 3'b001, 0, 0, 0, 0);
    chk_regs("R3 saturated");
    cyc("R7 clear all with nonposted drop", 3'b010, 1, 2'd1, 24'd0, 0);
    chk_regs("R7 drop beats counter clear");
  endtask

  task automatic t_severity_modes();
    cyc("R6 all classes quiet", 3'b000, 1, 2'd2, 24'd0, 0);
    cyc("R6 clear flags", 3'b000, 1, 2'd0, 24'd7, 0);
    cyc("R6 code 00 silent", 3'b111, 0, 0, 0, 0);
    cyc("R6 two corr classes", 3'b000, 1, 2'd2, 24'b00_01_01, 0);
    cyc("R6 clear flags again", 3'b000, 1, 2'd0, 24'd7, 0);
    cyc("R6 posted+nonposted corr only", 3'b011, 0, 0, 0, 0);
    cyc("R6 mixed severities", 3'b000, 1, 2'd2, 24'b11_10_00, 0);
    cyc("R6 clear flags third", 3'b000, 1, 2'd0, 24'd7, 0);
    cyc("R6 nonfatal and fatal together", 3'b110, 0, 0, 0, 0);
    chk_regs("R6 after mode tests");
  endtask

  task automatic t_hot();
    cyc("R8 clear posted before hot", 3'b000, 1, 2'd0, 24'd1, 0);
    cyc("R8 setting posted fatal", 3'b000, 1, 2'd2, 24'b11_10_11, 0);
    cyc("R8 drop under hot reset silent", 3'b001, 0, 0, 0, 1);
    chk_regs("R8 hot reset keeps state");
  endtask

  task automatic t_cold_again();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    t_reset();
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_severity_setup();
    t_first_drops();
    t_w1c();
    t_counter();
    t_severity_modes();
    t_hot();
    t_cold_again();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule